// File: doc/BRIEF.md
# Condition Code Register with Interrupt Acceptance

This block holds the 8-bit condition code byte of a small processor and decides when an external interrupt is taken. Five bits carry state: a half-carry flag, the interrupt mask, and the negative, zero and carry flags. The three upper bits are tied high. Each flag-updating ALU cycle writes the arithmetic flags from the result byte and from the carries out of bit 3 and bit 7. The half-carry flag changes only for the add class of operations. Dedicated strobes set or clear the mask. A return-from-interrupt strobe reloads the five live bits from a stacked byte.

An interrupt request seen while the mask is clear and no entry is in progress produces `take_irq_o` for the sequencer in that same cycle. The sequencer stacks the registers and then strobes `stk_done_i`. The mask is set on that strobe, before the vector fetch. A request seen while the mask is set, or while an entry is already in progress, is kept in a single pending latch. That latch is served automatically once the mask is clear again. Reset sets the mask and empties the latch, and the arithmetic flags keep their values through it.

Top module: `ccr_unit`

## Requirements
- R1: Bits 7, 6 and 5 of `ccr_o` always read 1.
- R2: While and after reset, the mask (`ccr_o` bit 3) is 1, `pend_o` is 0 and `take_irq_o` is 0.
- R3: On a cycle with `upd_en_i`=1, `op_add_i`=1 and no `rti_i`, the next `ccr_o` has bit 4 (H) = `c3_i`, bit 2 (N) = `res_i[7]`, bit 1 (Z) = 1 exactly when `res_i` is 0, and bit 0 (C) = `c7_i`.
- R4: On a cycle with `upd_en_i`=1 and `op_add_i`=0, N, Z and C update as in R3 and H keeps its value.
- R5: With `upd_en_i`=0 and no `rti_i`, H, N, Z and C hold, whatever `res_i`, `c3_i` and `c7_i` are.
- R6: `sei_i` sets the mask on the next edge and `cli_i` clears it. If both are high, set wins.
- R7: `take_irq_o` is 1 in the same cycle as `irq_i` when the mask is 0 and no entry is in progress. The mask stays 0 until `stk_done_i`, and becomes 1 on the edge where `stk_done_i` is seen.
- R8: A request seen while the mask is 1 raises no `take_irq_o` and sets `pend_o` on the next edge.
- R9: With `pend_o`=1, clearing the mask causes `take_irq_o` with no further request. `pend_o` is 0 after that accepting edge.
- R10: `rti_i` loads bits 4..0 of `ccr_o` from bits 4..0 of `stk_ccr_i`. It takes priority over flag updates, `sei_i` and `cli_i` in the same cycle.
- R11: Between `take_irq_o` and the following `stk_done_i`, no further `take_irq_o` occurs. A request in that window is latched as pending.
- R12: Reset leaves H, N, Z and C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Write arithmetic flags this cycle |
| op_add_i | input | 1 | Add class: H is written too |
| res_i | input | 8 | ALU result byte |
| c3_i | input | 1 | Carry out of bit 3 |
| c7_i | input | 1 | Carry or borrow out of bit 7 |
| sei_i | input | 1 | Set mask |
| cli_i | input | 1 | Clear mask |
| rti_i | input | 1 | Restore from stacked byte |
| stk_ccr_i | input | 8 | Stacked condition code byte |
| irq_i | input | 1 | External interrupt request |
| stk_done_i | input | 1 | Sequencer finished stacking |
| ccr_o | output | 8 | Condition code byte |
| take_irq_o | output | 1 | Accept interrupt, one cycle |
| pend_o | output | 1 | Request latched and waiting |

## Verification
The hardest case to reach is a latched request that gets served with no request present. This needs the mask set, a request that is then withdrawn, and only afterwards a mask clear. The bench builds that order explicitly, then looks for the accept pulse with `irq_i` low and checks that `pend_o` falls. It also drives a request during the stacking window to show that it is parked, not accepted twice. Flag retention through reset is checked by loading known flags with a restore, pulsing reset, and reading the byte back.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int BIT_H = 4;
  localparam int BIT_I = 3;
  localparam int BIT_N = 2;
  localparam int BIT_Z = 1;
  localparam int BIT_C = 0;
  localparam logic [2:0] CCR_TOP = 3'b111;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/ccr_flag_logic.sv
module ccr_flag_logic
  import ccr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          upd_en_i,
  input  logic          op_add_i,
  input  logic [DW-1:0] res_i,
  input  logic          c3_i,
  input  logic          c7_i,
  input  logic          rti_i,
  input  logic [4:0]    stk_lo_i,
  input  arith_flags_t  cur_i,
  output arith_flags_t  nxt_o
);
  localparam int MSB = DW - 1;

  always_comb begin
    nxt_o = cur_i;
    if (rti_i) begin
      nxt_o.h = stk_lo_i[BIT_H];
      nxt_o.n = stk_lo_i[BIT_N];
      nxt_o.z = stk_lo_i[BIT_Z];
      nxt_o.c = stk_lo_i[BIT_C];
    end else if (upd_en_i) begin
      if (op_add_i) nxt_o.h = c3_i;
      nxt_o.n = res_i[MSB];
      nxt_o.z = (res_i == '0);
      nxt_o.c = c7_i;
    end
  end
endmodule

// File: rtl/ccr_irq_ctrl.sv
module ccr_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sei_i,
  input  logic cli_i,
  input  logic rti_i,
  input  logic rti_mask_i,
  input  logic stk_done_i,
  input  logic irq_i,
  output logic mask_o,
  output logic take_o,
  output logic pend_o
);
  logic mask_q, pend_q, entry_q;

  assign take_o = !mask_q && !entry_q && (irq_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b1;
      pend_q  <= 1'b0;
      entry_q <= 1'b0;
    end else begin
      // mask: stacking done > restore > set > clear
      if (stk_done_i && entry_q) mask_q <= 1'b1;
      else if (rti_i)            mask_q <= rti_mask_i;
      else if (sei_i)            mask_q <= 1'b1;
      else if (cli_i)            mask_q <= 1'b0;

      if (take_o)                    entry_q <= 1'b1;
      else if (stk_done_i)           entry_q <= 1'b0;

      if (take_o)     pend_q <= 1'b0;
      else if (irq_i) pend_q <= 1'b1;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_en_i,
  input  logic       op_add_i,
  input  logic [7:0] res_i,
  input  logic       c3_i,
  input  logic       c7_i,
  input  logic       sei_i,
  input  logic       cli_i,
  input  logic       rti_i,
  input  logic [7:0] stk_ccr_i,
  input  logic       irq_i,
  input  logic       stk_done_i,
  output logic [7:0] ccr_o,
  output logic       take_irq_o,
  output logic       pend_o
);
  arith_flags_t flags_q, flags_d;
  logic         mask;

  ccr_flag_logic #(.DW(CCR_W)) u_flags (
    .upd_en_i (upd_en_i),
    .op_add_i (op_add_i),
    .res_i    (res_i),
    .c3_i     (c3_i),
    .c7_i     (c7_i),
    .rti_i    (rti_i),
    .stk_lo_i (stk_ccr_i[4:0]),
    .cur_i    (flags_q),
    .nxt_o    (flags_d)
  );

  ccr_irq_ctrl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sei_i      (sei_i),
    .cli_i      (cli_i),
    .rti_i      (rti_i),
    .rti_mask_i (stk_ccr_i[BIT_I]),
    .stk_done_i (stk_done_i),
    .irq_i      (irq_i),
    .mask_o     (mask),
    .take_o     (take_irq_o),
    .pend_o     (pend_o)
  );

  // arithmetic flags are deliberately not reset
  always_ff @(posedge clk_i) begin
    if (rst_ni) flags_q <= flags_d;
  end

  assign ccr_o = {CCR_TOP, flags_q.h, mask, flags_q.n, flags_q.z, flags_q.c};
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd_en_i,
  input logic       op_add_i,
  input logic [7:0] res_i,
  input logic       c3_i,
  input logic       c7_i,
  input logic       sei_i,
  input logic       cli_i,
  input logic       rti_i,
  input logic [7:0] stk_ccr_i,
  input logic       irq_i,
  input logic       stk_done_i,
  input logic [7:0] ccr_o,
  input logic       take_irq_o,
  input logic       pend_o
);
  // R1
  top_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_o[7:5] == 3'b111);

  // R3
  half_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && op_add_i && !rti_i |=> ccr_o[4] == $past(c3_i));

  // R6
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sei_i && !rti_i |=> ccr_o[3]);

  // R7
  take_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> !ccr_o[3]);

  // R8
  latch_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && ccr_o[3] |=> pend_o);

  // R9
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |=> !pend_o);

  // R11
  single_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |=> !take_irq_o);
endmodule

bind ccr_unit ccr_unit_chk u_chk (.*);

// File: tb/tb_ccr_unit.sv
`timescale 1ns/1ps
module tb_ccr_unit;
  logic       clk_i = 0, rst_ni = 0;
  logic       upd_en_i = 0, op_add_i = 0, c3_i = 0, c7_i = 0;
  logic [7:0] res_i = 0, stk_ccr_i = 0;
  logic       sei_i = 0, cli_i = 0, rti_i = 0, irq_i = 0, stk_done_i = 0;
  logic [7:0] ccr_o;
  logic       take_irq_o, pend_o;
  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  ccr_unit dut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic idle;
    upd_en_i = 0; sei_i = 0; cli_i = 0; rti_i = 0; irq_i = 0; stk_done_i = 0;
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic eh;
    logic [7:0] exp;
    @(negedge clk_i);
    // R2 during reset
    chk({ccr_o[3], pend_o, take_irq_o}, 8'b100, "R2 in reset");
    irq_i = 1; #1;
    chk({7'd0, take_irq_o}, 8'd0, "R2 no take in reset");
    irq_i = 0;
    step; rst_ni = 1; step;
    chk({ccr_o[3], pend_o, take_irq_o}, 8'b100, "R2 after reset");

    // load known flags through restore: H=1 N=0 Z=1 C=0, I stays 1
    rti_i = 1; stk_ccr_i = 8'h1A; step; idle;
    chk(ccr_o, 8'hFA, "R10 restore");
    eh = 1'b1;

    // R3/R4 exhaustive sweep
    for (int cls = 0; cls < 2; cls++)
      for (int r = 0; r < 256; r++)
        for (int cv = 0; cv < 4; cv++) begin
          upd_en_i = 1; op_add_i = cls[0]; res_i = r[7:0];
          c3_i = cv[0]; c7_i = cv[1];
          step;
          if (cls == 1) eh = cv[0];
          exp = {3'b111, eh, 1'b1, r[7], (r == 0), cv[1]};
          chk(ccr_o, exp, cls == 1 ? "R3 add update" : "R4 other update");
        end
    idle;

    // R5 hold with garbage inputs
    exp = ccr_o;
    for (int k = 0; k < 8; k++) begin
      res_i = 8'(k * 37); c3_i = k[0]; c7_i = k[1]; op_add_i = k[2];
      step;
      chk(ccr_o, exp, "R5 hold");
    end

    // R10 priority over update and cli
    rti_i = 1; stk_ccr_i = 8'h0D; upd_en_i = 1; op_add_i = 1; c3_i = 1;
    res_i = 8'h80; cli_i = 1; step; idle;
    chk(ccr_o, 8'hED, "R10 priority");

    // R12 flags survive reset
    rst_ni = 0; step;
    chk(ccr_o, 8'hED, "R12 in reset");
    rst_ni = 1; step;
    chk(ccr_o, 8'hED, "R12 after reset");

    // R6
    cli_i = 1; step; idle;
    chk({7'd0, ccr_o[3]}, 8'd0, "R6 clear");
    sei_i = 1; cli_i = 1; step; idle;
    chk({7'd0, ccr_o[3]}, 8'd1, "R6 set wins");
    cli_i = 1; step; idle;

    // R7 unmasked accept
    irq_i = 1; #1;
    chk({7'd0, take_irq_o}, 8'd1, "R7 take same cycle");
    step;
    chk({ccr_o[3], take_irq_o, pend_o}, 8'b000, "R7 mask held until stacked");
    // R11: request during stacking window is parked
    chk({7'd0, take_irq_o}, 8'd0, "R11 no second take");
    step; irq_i = 0;
    chk({7'd0, pend_o}, 8'd1, "R11 parked as pending");
    stk_done_i = 1; step; idle;
    chk({ccr_o[3], take_irq_o}, 8'b10, "R7 mask set after stacking");

    // R8 masked request latched (already pending from R11; clear it first)
    rst_ni = 0; step; rst_ni = 1; step;
    irq_i = 1; #1;
    chk({7'd0, take_irq_o}, 8'd0, "R8 no take when masked");
    step; idle;
    chk({7'd0, pend_o}, 8'd1, "R8 pending set");

    // R9 serviced on mask clear with no request present
    cli_i = 1; step; idle; #1;
    chk({pend_o, take_irq_o}, 8'b11, "R9 take from pending");
    step;
    chk({pend_o, take_irq_o}, 8'b00, "R9 pending cleared");
    stk_done_i = 1; step; idle;
    chk({7'd0, ccr_o[3]}, 8'd1, "R9 mask set after entry");
    chk(ccr_o & 8'hE0, 8'hE0, "R1 fixed bits");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule